// File: doc/BRIEF.md
# Read Deskew Edge Alignment Adjuster

This block runs one time after reset, following a read sweep with a reference pattern. For each byte lane it receives the per-bit first-passing tap (from the upward search) and the per-bit last-passing tap (from the downward search), along with one lock flag per search direction. It works out whether the lane's passing window is pressed against the low or the high end of the delay range. If it is, the block changes the lane's per-bit read deskew values so that the eye moves back toward the middle. It also reports the resulting window width for every lane.

Lanes are handled strictly one at a time, starting at lane 0. The block fetches each deskew value over a simple register port with one cycle of read latency, then writes the new value back. A bit-to-pad map, set by a parameter, turns (lane, bit) into a register position. A busy flag stays high for the whole operation. A single-cycle done pulse ends it, and a fail flag carries the status.

Top module: `read_deskew_aligner`

## Requirements
- R1: The adjustment runs once per reset. A start seen after a completed run makes done rise in the next cycle with busy low and fail low. It causes no register access and leaves the window outputs unchanged.
- R2: A lane counts as unlocked if either of its two lock flags is low. When the block reaches an unlocked lane, it stops there: done pulses with fail high. Lanes handled before it keep their updates. That lane and every later lane see no register access, and their window outputs keep their previous value.
- R3: When the largest start tap in a lane is 1 or less, all eight of the lane's deskew values are read. Each one is written back as the old value plus 10, limited to 31.
- R4: When the smallest end tap in a lane is greater than 30, the registers at raw positions 4 and 5 of that lane (address lane*8+4 and lane*8+5, with no pad mapping) are read. Each is written back as the old value plus 10, wrapping modulo 32.
- R5: If both conditions hold in one lane, the eight low-edge updates come first, in bit order 0 to 7. Position 4 and then position 5 follow. A lane that meets neither condition gets no access.
- R6: After a lane has been evaluated, its window output equals (smallest end tap − largest start tap + 1) modulo 64. Every window output is zero after reset.
- R7: The register address for lane l, bit b during the low-edge update is l*8 + map(l,b). In the default map, map(l,b) = 7 − b.
- R8: The block never asserts read and write together. The read data is taken in the cycle after the read strobe. The matching write goes to the same address in that same cycle.
- R9: Busy rises in the cycle after an accepted start and stays high until the operation ends. Done is a one-cycle pulse in the first cycle that busy is low again.
- R10: After reset, busy, done, fail and the register strobes are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| lock_lo | input | NUM_LANES | Upward-search lock flag per lane |
| lock_hi | input | NUM_LANES | Downward-search lock flag per lane |
| start_taps | input | NUM_LANES*LANE_BITS*TAP_W | Per-bit first-passing tap; lane l bit b at [(l*LANE_BITS+b)*TAP_W +: TAP_W] |
| end_taps | input | NUM_LANES*LANE_BITS*TAP_W | Per-bit last-passing tap, same packing |
| reg_rd_en | output | 1 | Deskew register read strobe |
| reg_wr_en | output | 1 | Deskew register write strobe |
| reg_addr | output | ADDR_W | Deskew register address |
| reg_wdata | output | DSK_W | Updated deskew value |
| reg_rdata | input | DSK_W | Read data, valid the cycle after reg_rd_en |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last operation stopped on an unlocked lane |
| win_size | output | NUM_LANES*TAP_W | Window width per lane |

## Verification
A wrong lane index or a wrong pad mapping shows up on the very first write of the affected lane, as an address mismatch. A broken saturating or wrapping adder shows up in the write data in that same cycle. A wrong threshold comparison or a wrong min/max tree changes the number of writes, or their order, for the boundary lanes that sit exactly at start tap 1 and 2, or at end tap 30 and 31. A run-once flag that is lost or never set shows up either as extra writes after a second start, or as a done pulse that comes late. A lock check that does not stop the run shows up as writes to lanes after the failing one, and as non-zero window outputs for those lanes.

// File: rtl/rdskew_pkg.sv
package rdskew_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVAL,
      ST_READ,
      ST_WRITE,
      ST_NEXT,
      ST_FIN
   } rdskew_state_e;

   typedef enum logic {
      PH_LEFT,
      PH_RIGHT
   } rdskew_phase_e;

endpackage

// File: rtl/rdskew_lane_stats.sv
module rdskew_lane_stats #(
   parameter int LANE_BITS = 8,
   parameter int TAP_W     = 6
)(
   input  logic [LANE_BITS*TAP_W-1:0] lane_start,
   input  logic [LANE_BITS*TAP_W-1:0] lane_end,
   output logic [TAP_W-1:0]           max_start,
   output logic [TAP_W-1:0]           min_end,
   output logic [TAP_W-1:0]           win
);

   logic [TAP_W-1:0] mx [LANE_BITS];
   logic [TAP_W-1:0] mn [LANE_BITS];

   for (genvar b = 0; b < LANE_BITS; b++) begin : g_chain
      logic [TAP_W-1:0] s_b;
      logic [TAP_W-1:0] e_b;
      assign s_b = lane_start[b*TAP_W +: TAP_W];
      assign e_b = lane_end[b*TAP_W +: TAP_W];
      if (b == 0) begin : g_first
         assign mx[b] = s_b;
         assign mn[b] = e_b;
      end else begin : g_rest
         assign mx[b] = (s_b > mx[b-1]) ? s_b : mx[b-1];
         assign mn[b] = (e_b < mn[b-1]) ? e_b : mn[b-1];
      end
   end

   assign max_start = mx[LANE_BITS-1];
   assign min_end   = mn[LANE_BITS-1];
   assign win       = min_end - max_start + TAP_W'(1);

endmodule

// File: rtl/rdskew_step.sv
module rdskew_step #(
   parameter int DSK_W    = 5,
   parameter int STEP     = 10,
   parameter int DSK_CAP  = 31,
   parameter bit SATURATE = 1'b1
)(
   input  logic [DSK_W-1:0] cur,
   output logic [DSK_W-1:0] nxt
);

   if (SATURATE) begin : g_sat
      localparam logic [DSK_W:0] STEP_X = (DSK_W+1)'(STEP);
      localparam logic [DSK_W:0] CAP_X  = (DSK_W+1)'(DSK_CAP);
      logic [DSK_W:0] sum;
      assign sum = {1'b0, cur} + STEP_X;
      assign nxt = (sum > CAP_X) ? CAP_X[DSK_W-1:0] : sum[DSK_W-1:0];
   end else begin : g_wrap
      assign nxt = cur + DSK_W'(STEP);
   end

endmodule

// File: rtl/read_deskew_aligner.sv
module read_deskew_aligner
   import rdskew_pkg::*;
#(
   parameter int NUM_LANES   = 4,
   parameter int LANE_BITS   = 8,
   parameter int TAP_W       = 6,
   parameter int DSK_W       = 5,
   parameter int LEFT_LIMIT  = 1,
   parameter int RIGHT_LIMIT = 30,
   parameter int STEP        = 10,
   parameter int DSK_CAP     = 31,
   parameter int RIGHT_POS_A = 4,
   parameter int RIGHT_POS_B = 5,
   parameter int PAD_W       = $clog2(LANE_BITS),
   parameter logic [NUM_LANES*LANE_BITS*PAD_W-1:0] PAD_MAP = {4{24'h053977}},
   localparam int ADDR_W     = $clog2(NUM_LANES*LANE_BITS)
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic [NUM_LANES-1:0]             lock_lo,
   input  logic [NUM_LANES-1:0]             lock_hi,
   input  logic [NUM_LANES*LANE_BITS*TAP_W-1:0] start_taps,
   input  logic [NUM_LANES*LANE_BITS*TAP_W-1:0] end_taps,
   output logic                             reg_rd_en,
   output logic                             reg_wr_en,
   output logic [ADDR_W-1:0]                reg_addr,
   output logic [DSK_W-1:0]                 reg_wdata,
   input  logic [DSK_W-1:0]                 reg_rdata,
   output logic                             busy,
   output logic                             done,
   output logic                             fail,
   output logic [NUM_LANES*TAP_W-1:0]       win_size
);

   localparam int LANE_W  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
   localparam int IDX_W   = PAD_W;
   localparam int SLICE_W = LANE_BITS*TAP_W;
   localparam logic [TAP_W-1:0]  LEFT_T    = TAP_W'(LEFT_LIMIT);
   localparam logic [TAP_W-1:0]  RIGHT_T   = TAP_W'(RIGHT_LIMIT);
   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES-1);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(LANE_BITS-1);
   localparam logic [DSK_W:0]    STEP_X    = (DSK_W+1)'(STEP);
   localparam logic [DSK_W-1:0]  CAP_V     = DSK_W'(DSK_CAP);

   // elaboration-time parameter checks
   if (LANE_BITS < 2 || RIGHT_POS_A >= LANE_BITS || RIGHT_POS_B >= LANE_BITS) begin : g_bad_pos
      $error("right-edge positions must lie inside the lane");
   end
   if (DSK_CAP >= (1 << DSK_W) || STEP >= (1 << DSK_W)) begin : g_bad_dsk
      $error("cap and step must fit the deskew width");
   end
   if (LEFT_LIMIT >= (1 << TAP_W) || RIGHT_LIMIT >= (1 << TAP_W)) begin : g_bad_tap
      $error("edge limits must fit the tap width");
   end

   rdskew_state_e    state_q;
   rdskew_phase_e    phase_q;
   logic [LANE_W-1:0] lane_q;
   logic [IDX_W-1:0]  idx_q;
   logic             do_right_q;
   logic             ran_q;
   logic             fail_q;
   logic             done_q;
   logic [TAP_W-1:0] win_q [NUM_LANES];

   // selected lane statistics
   logic [SLICE_W-1:0] sel_start;
   logic [SLICE_W-1:0] sel_end;
   logic [TAP_W-1:0]   lane_max_start;
   logic [TAP_W-1:0]   lane_min_end;
   logic [TAP_W-1:0]   lane_win;
   logic               lane_locked;
   logic               need_left;
   logic               need_right;

   assign sel_start   = start_taps[int'(lane_q)*SLICE_W +: SLICE_W];
   assign sel_end     = end_taps[int'(lane_q)*SLICE_W +: SLICE_W];
   assign lane_locked = lock_lo[lane_q] & lock_hi[lane_q];

   rdskew_lane_stats #(
      .LANE_BITS (LANE_BITS),
      .TAP_W     (TAP_W)
   ) u_stats (
      .lane_start (sel_start),
      .lane_end   (sel_end),
      .max_start  (lane_max_start),
      .min_end    (lane_min_end),
      .win        (lane_win)
   );

   assign need_left  = (lane_max_start <= LEFT_T);
   assign need_right = (lane_min_end > RIGHT_T);

   // address generation
   logic [PAD_W-1:0] pad;
   always_comb begin
      if (phase_q == PH_LEFT) begin
         pad = PAD_MAP[(int'(lane_q)*LANE_BITS + int'(idx_q))*PAD_W +: PAD_W];
      end else begin
         pad = idx_q[0] ? PAD_W'(RIGHT_POS_B) : PAD_W'(RIGHT_POS_A);
      end
   end

   // update arithmetic
   logic [DSK_W-1:0] sat_next;
   logic [DSK_W-1:0] wrap_next;

   rdskew_step #(
      .DSK_W    (DSK_W),
      .STEP     (STEP),
      .DSK_CAP  (DSK_CAP),
      .SATURATE (1'b1)
   ) u_step_sat (
      .cur (reg_rdata),
      .nxt (sat_next)
   );

   rdskew_step #(
      .DSK_W    (DSK_W),
      .STEP     (STEP),
      .DSK_CAP  (DSK_CAP),
      .SATURATE (1'b0)
   ) u_step_wrap (
      .cur (reg_rdata),
      .nxt (wrap_next)
   );

   assign reg_rd_en = (state_q == ST_READ);
   assign reg_wr_en = (state_q == ST_WRITE);
   assign reg_addr  = ADDR_W'(int'(lane_q)*LANE_BITS) + ADDR_W'(pad);
   assign reg_wdata = (phase_q == PH_LEFT) ? sat_next : wrap_next;
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign fail      = fail_q;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_win_out
      assign win_size[l*TAP_W +: TAP_W] = win_q[l];
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= PH_LEFT;
         lane_q     <= '0;
         idx_q      <= '0;
         do_right_q <= 1'b0;
         ran_q      <= 1'b0;
         fail_q     <= 1'b0;
         done_q     <= 1'b0;
         for (int l = 0; l < NUM_LANES; l++) begin
            win_q[l] <= '0;
         end
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  fail_q <= 1'b0;
                  if (ran_q) begin
                     done_q <= 1'b1;
                  end else begin
                     ran_q   <= 1'b1;
                     lane_q  <= '0;
                     state_q <= ST_EVAL;
                  end
               end
            end
            ST_EVAL: begin
               if (!lane_locked) begin
                  fail_q  <= 1'b1;
                  state_q <= ST_FIN;
               end else begin
                  win_q[lane_q] <= lane_win;
                  do_right_q    <= need_right;
                  idx_q         <= '0;
                  if (need_left) begin
                     phase_q <= PH_LEFT;
                     state_q <= ST_READ;
                  end else if (need_right) begin
                     phase_q <= PH_RIGHT;
                     state_q <= ST_READ;
                  end else begin
                     state_q <= ST_NEXT;
                  end
               end
            end
            ST_READ: begin
               state_q <= ST_WRITE;
            end
            ST_WRITE: begin
               if (phase_q == PH_LEFT) begin
                  if (idx_q != LAST_IDX) begin
                     idx_q   <= idx_q + IDX_W'(1);
                     state_q <= ST_READ;
                  end else if (do_right_q) begin
                     phase_q <= PH_RIGHT;
                     idx_q   <= '0;
                     state_q <= ST_READ;
                  end else begin
                     state_q <= ST_NEXT;
                  end
               end else begin
                  if (!idx_q[0]) begin
                     idx_q   <= IDX_W'(1);
                     state_q <= ST_READ;
                  end else begin
                     state_q <= ST_NEXT;
                  end
               end
            end
            ST_NEXT: begin
               if (lane_q == LAST_LANE) begin
                  state_q <= ST_FIN;
               end else begin
                  lane_q  <= lane_q + LANE_W'(1);
                  state_q <= ST_EVAL;
               end
            end
            ST_FIN: begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: strobes never overlap
   a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd_en && reg_wr_en));

   // R8: each write follows a read of the same address
   a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> ($past(reg_rd_en) && reg_addr == $past(reg_addr)));

   // R3: low-edge update is a capped increment of the fetched value
   a_r3_capped_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && phase_q == PH_LEFT) |->
         (reg_wdata <= CAP_V) &&
         (reg_wdata == CAP_V || {1'b0, reg_wdata} == {1'b0, reg_rdata} + STEP_X));

   // R4: high-edge update wraps in the register width
   a_r4_wrapped_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && phase_q == PH_RIGHT) |->
         ({1'b0, reg_wdata} == (({1'b0, reg_rdata} + STEP_X) & {1'b0, {DSK_W{1'b1}}})));

   // R9: no register traffic while idle
   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_rd_en && !reg_wr_en));

   // R1: a repeated start completes in the next cycle
   a_r1_repeat_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && ran_q) |=> (done && !busy && !fail));

   // R2: a raised failure is followed by the done pulse
   a_r2_fail_ends: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |=> (done && !busy));

endmodule

// File: tb/tb_read_deskew_aligner.sv
module tb_read_deskew_aligner;

   localparam int NL = 4;
   localparam int NB = 8;
   localparam int TW = 6;
   localparam int DW = 5;
   localparam int AW = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NL-1:0]     lk_lo = '1;
   logic [NL-1:0]     lk_hi = '1;
   logic [NL*NB*TW-1:0] st_taps = '0;
   logic [NL*NB*TW-1:0] en_taps = '0;
   logic              reg_rd_en;
   logic              reg_wr_en;
   logic [AW-1:0]     reg_addr;
   logic [DW-1:0]     reg_wdata;
   logic [DW-1:0]     reg_rdata = '0;
   logic              busy;
   logic              done;
   logic              fail;
   logic [NL*TW-1:0]  win_size;

   always #5 clk = ~clk;

   read_deskew_aligner dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .lock_lo    (lk_lo),
      .lock_hi    (lk_hi),
      .start_taps (st_taps),
      .end_taps   (en_taps),
      .reg_rd_en  (reg_rd_en),
      .reg_wr_en  (reg_wr_en),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .busy       (busy),
      .done       (done),
      .fail       (fail),
      .win_size   (win_size)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [DW-1:0] mem [32];
   int            exp_mem [32];
   int            exp_win [NL];
   bit            exp_fail;
   logic [AW+DW-1:0] expq [$];

   task automatic check(string req, bit ok, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // register model and scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_rd_en) reg_rdata <= mem[reg_addr];
         if (reg_wr_en) begin
            if (expq.size() == 0) begin
               check("R1/R2 unexpected write", 1'b0, int'(reg_addr), -1);
            end else begin
               logic [AW+DW-1:0] e;
               e = expq.pop_front();
               check("R3/R4/R5/R7 write address", reg_addr == e[AW+DW-1:DW],
                     int'(reg_addr), int'(e[AW+DW-1:DW]));
               check("R3/R4 write data", reg_wdata == e[DW-1:0],
                     int'(reg_wdata), int'(e[DW-1:0]));
            end
            mem[reg_addr] = reg_wdata;
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic set_lane(int l, int smin, int smax, int emin, int emax);
      for (int b = 0; b < NB; b++) begin
         st_taps[(l*NB+b)*TW +: TW] = TW'((b == 3) ? smax : smin);
         en_taps[(l*NB+b)*TW +: TW] = TW'((b == 5) ? emin : emax);
      end
   endtask

   task automatic load_mem(int mul, int add);
      for (int i = 0; i < 32; i++) begin
         mem[i] = DW'((i*mul + add) % 32);
         exp_mem[i] = (i*mul + add) % 32;
      end
   endtask

   // driver: predicts the write stream, final contents and status
   task automatic predict();
      exp_fail = 1'b0;
      for (int l = 0; l < NL; l++) begin
         int smax;
         int emin;
         if (!(lk_lo[l] && lk_hi[l])) begin
            exp_fail = 1'b1;
            break;
         end
         smax = 0;
         emin = 63;
         for (int b = 0; b < NB; b++) begin
            if (int'(st_taps[(l*NB+b)*TW +: TW]) > smax) smax = int'(st_taps[(l*NB+b)*TW +: TW]);
            if (int'(en_taps[(l*NB+b)*TW +: TW]) < emin) emin = int'(en_taps[(l*NB+b)*TW +: TW]);
         end
         exp_win[l] = (emin - smax + 1) & 63;
         if (smax <= 1) begin
            for (int b = 0; b < NB; b++) begin
               int a;
               int v;
               a = l*NB + (7 - b);
               v = exp_mem[a] + 10;
               if (v > 31) v = 31;
               exp_mem[a] = v;
               expq.push_back({AW'(a), DW'(v)});
            end
         end
         if (emin > 30) begin
            for (int p = 4; p <= 5; p++) begin
               int a;
               int v;
               a = l*NB + p;
               v = (exp_mem[a] + 10) % 32;
               exp_mem[a] = v;
               expq.push_back({AW'(a), DW'(v)});
            end
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      for (int l = 0; l < NL; l++) exp_win[l] = 0;
      repeat (3) @(negedge clk);
      check("R10 busy after reset", busy == 1'b0, busy, 0);
      check("R10 done after reset", done == 1'b0, done, 0);
      check("R10 fail after reset", fail == 1'b0, fail, 0);
      check("R10 strobes after reset", !reg_rd_en && !reg_wr_en,
            int'({reg_rd_en, reg_wr_en}), 0);
      check("R6 window zero after reset", win_size == '0, int'(win_size), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_final(string tag);
      check({tag, " R2 fail status"}, fail == exp_fail, fail, exp_fail);
      check({tag, " R9 busy low at done"}, busy == 1'b0, busy, 0);
      check({tag, " R5 all writes seen"}, expq.size() == 0, expq.size(), 0);
      for (int l = 0; l < NL; l++) begin
         check({tag, " R6 window"}, int'(win_size[l*TW +: TW]) == exp_win[l],
               int'(win_size[l*TW +: TW]), exp_win[l]);
      end
      for (int i = 0; i < 32; i++) begin
         check({tag, " R3/R4 register contents"}, int'(mem[i]) == exp_mem[i],
               int'(mem[i]), exp_mem[i]);
      end
   endtask

   task automatic full_run(string tag);
      int n;
      predict();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({tag, " R9 busy after start"}, busy == 1'b1, busy, 1);
      n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check({tag, " R9 done pulse"}, done == 1'b1, done, 1);
      check_final(tag);
      @(negedge clk);
      check({tag, " R9 done single cycle"}, done == 1'b0, done, 0);
   endtask

   initial begin
      // scenario A: all lanes locked, mixed edge cases
      load_mem(7, 3);
      for (int i = 24; i < 32; i++) begin
         mem[i] = DW'(28);
         exp_mem[i] = 28;
      end
      set_lane(0, 0, 1, 20, 25);   // start max 1: low edge only
      set_lane(1, 5, 8, 31, 40);   // end min 31: high edge only
      set_lane(2, 0, 2, 30, 45);   // start max 2, end min 30: neither
      set_lane(3, 0, 0, 33, 50);   // both; low edge saturates, high edge wraps
      do_reset();
      full_run("A");

      // R1: second start does nothing but pulse done at once
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R1 repeat done next cycle", done == 1'b1, done, 1);
      check("R1 repeat busy low", busy == 1'b0, busy, 0);
      check("R1 repeat fail low", fail == 1'b0, fail, 0);
      repeat (20) @(negedge clk);
      exp_fail = 1'b0;
      check_final("R1 repeat");

      // scenario B: lane 1 lacks downward lock
      load_mem(3, 1);
      set_lane(0, 1, 1, 10, 12);
      set_lane(1, 0, 0, 40, 41);
      set_lane(2, 3, 4, 35, 36);
      lk_hi = 4'b1101;
      do_reset();
      full_run("B");

      // scenario C: lane 0 lacks upward lock
      load_mem(5, 9);
      lk_hi = 4'b1111;
      lk_lo = 4'b1110;
      do_reset();
      full_run("C");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule